// File: doc/BRIEF.md
# Counter-Ramp Conversion Controller

This block is the digital half of a counter-ramp analog-to-digital converter. Its count output drives an external DAC. An external comparator reports when the DAC level has climbed past the analog input, and the block returns that as a single bit. A start pulse zeroes the count and keeps it parked there for as long as the pulse lasts. Once the pulse drops, the count climbs by one code per clock. At the first clock on which the comparator reports a crossing, the count freezes, and the frozen value is the conversion result.

Some inputs sit beyond the last DAC step, so the comparator never trips. For these the block stops at the all-ones code and raises an over-range flag. Without this stop the count would wrap and the DAC would ramp again and again. A busy output is high from start until the conversion ends, and its falling edge marks the result as valid. A start pulse that arrives mid-conversion throws the partial count away and begins again.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, code_o is 0, busy_o is low and ovr_o is low, and they stay that way until start_i is seen high.
- R2: On every clock edge where start_i is high, the next cycle shows code_o = 0, busy_o high and ovr_o low, whatever the comparator reports.
- R3: While busy_o is high, start_i is low, cmp_i is low and code_o is below all-ones, each clock edge raises code_o by exactly one.
- R4: While busy_o is high and start_i is low, a clock edge with cmp_i high makes busy_o low, leaves code_o at the value it had at that edge, and keeps ovr_o low.
- R5: With the comparator high exactly when code_o exceeds an input threshold T (T from -1 to 254), the result is T+1, and busy_o is first seen low after T+2 clock edges counted from the first edge with start_i low.
- R6: While busy_o is high and start_i is low, a clock edge with code_o all-ones and cmp_i low ends the conversion: code_o holds all-ones, busy_o goes low and ovr_o goes high. For T of 255 or more, this happens after 2^CNT_W edges.
- R7: Once busy_o is low, code_o, busy_o and ovr_o do not change, whatever cmp_i does, until start_i is high again.
- R8: A start_i pulse during a conversion abandons it. The count returns to 0 and the next ramp starts from 0.
- R9: A start_i pulse clears an ovr_o flag left by an earlier conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start/abort pulse; zeroes and holds the count while high |
| cmp_i | input | 1 | Comparator result, high when the DAC level exceeds the input (already synchronous) |
| code_o | output | CNT_W | Count driving the DAC; the conversion result once busy_o is low |
| busy_o | output | 1 | High from start until the conversion ends |
| ovr_o | output | 1 | Over-range: the ramp reached all-ones without a crossing |

## Verification
The bench goes after the top of the range, where T = 254, 255 and 300 sit side by side. Here a design that tested for the top code before testing the comparator would flag over-range on a valid 255 result. A design that lacked the stop would wrap to zero and never end the conversion. It checks that a T of -1 ends the conversion on the first edge. A design that counted one edge too early or too late would return the wrong code or take the wrong number of edges. It also toggles the comparator after the conversion ends and pulses start in the middle of a ramp. A design that leaked clocks into the held count, or ignored an abort, would then show a moving result or a count that does not restart from zero.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } ramp_phase_e;

   localparam int unsigned MIN_CNT_W = 2;
   localparam int unsigned MAX_CNT_W = 24;

endpackage

// File: rtl/ramp_adc_cnt.sv
module ramp_adc_cnt #(
   parameter int unsigned CNT_W      = 8,
   parameter bit          TOP_REDUCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             at_top
);
   localparam logic [CNT_W-1:0] TOP_CODE = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= cnt + 1'b1;
      end
   end

   generate
      if (TOP_REDUCE) begin : g_top_and
         assign at_top = &cnt;
      end else begin : g_top_cmp
         assign at_top = (cnt == TOP_CODE);
      end
   endgenerate

endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
   import ramp_adc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        cmp,
   input  logic        at_top,
   output logic        clr,
   output logic        inc,
   output logic        busy,
   output logic        ovr
);
   ramp_phase_e phase_q, phase_d;
   logic        ovr_d;
   logic        counting;

   assign counting = (phase_q == PH_RUN) && !start;

   always_comb begin
      phase_d = phase_q;
      ovr_d   = ovr;
      if (start) begin
         phase_d = PH_RUN;
         ovr_d   = 1'b0;
      end else if (phase_q == PH_RUN) begin
         if (cmp) begin
            phase_d = PH_DONE;
         end else if (at_top) begin
            phase_d = PH_DONE;
            ovr_d   = 1'b1;
         end
      end
   end

   assign clr  = start;
   assign inc  = counting && !cmp && !at_top;
   assign busy = (phase_q == PH_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         ovr     <= 1'b0;
      end else begin
         phase_q <= phase_d;
         ovr     <= ovr_d;
      end
   end

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
   import ramp_adc_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter bit          TOP_REDUCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic [CNT_W-1:0] code_o,
   output logic             busy_o,
   output logic             ovr_o
);
   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("ramp_adc_ctrl: CNT_W out of supported range");
      end
   endgenerate

   logic clr_w, inc_w, at_top_w;

   ramp_adc_seq seq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_i),
      .cmp    (cmp_i),
      .at_top (at_top_w),
      .clr    (clr_w),
      .inc    (inc_w),
      .busy   (busy_o),
      .ovr    (ovr_o)
   );

   ramp_adc_cnt #(
      .CNT_W      (CNT_W),
      .TOP_REDUCE (TOP_REDUCE)
   ) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_w),
      .inc    (inc_w),
      .cnt    (code_o),
      .at_top (at_top_w)
   );

endmodule

// File: rtl/ramp_adc_chk.sv
module ramp_adc_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             cmp_i,
   input logic [CNT_W-1:0] code_o,
   input logic             busy_o,
   input logic             ovr_o
);
   localparam logic [CNT_W-1:0] TOP_CODE = {CNT_W{1'b1}};

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (code_o == '0) && busy_o && !ovr_o);

   assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i && !cmp_i && code_o != TOP_CODE)
      |=> (code_o == CNT_W'($past(code_o) + 1'b1)) && busy_o);

   assert_cmp_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i && cmp_i) |=> !busy_o && $stable(code_o) && !ovr_o);

   assert_over_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i && !cmp_i && code_o == TOP_CODE)
      |=> !busy_o && ovr_o && (code_o == TOP_CODE));

   assert_hold_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> !busy_o && $stable(code_o) && $stable(ovr_o));

   assert_ovr_at_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |-> (code_o == TOP_CODE) && !busy_o);

endmodule

bind ramp_adc_ctrl ramp_adc_chk #(.CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .cmp_i   (cmp_i),
   .code_o  (code_o),
   .busy_o  (busy_o),
   .ovr_o   (ovr_o)
);

// File: tb/ramp_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ramp_adc_ctrl_tb_top;
   localparam int W = 8;
   localparam int TOP = (1 << W) - 1;
   localparam int NV = 10;
   localparam int THR   [NV] = '{-1, 0, 5, 99, 100, 200, 253, 254, 255, 300};
   localparam int E_CODE[NV] = '{ 0, 1, 6, 100, 101, 201, 254, 255, 255, 255};
   localparam int E_OVR [NV] = '{ 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
   localparam int E_CYC [NV] = '{ 1, 2, 7, 101, 102, 202, 255, 256, 256, 256};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic cmp_i;
   logic [W-1:0] code_o;
   logic busy_o, ovr_o;
   int thr = 1000;
   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   assign cmp_i = (int'(code_o) > thr);

   ramp_adc_ctrl #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .code_o(code_o), .busy_o(busy_o), .ovr_o(ovr_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         finish_run();
      end
   end

   task automatic pulse_start(input int len);
      @(negedge clk);
      start_i = 1'b1;
      repeat (len) @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      for (int k = 0; k < 600; k++) begin
         @(posedge clk);
         #1;
         n++;
         if (!busy_o) break;
      end
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk("R1", "code after reset", int'(code_o), 0);
      chk("R1", "busy after reset", int'(busy_o), 0);
      chk("R1", "ovr after reset", int'(ovr_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "code idle", int'(code_o), 0);
      chk("R1", "busy idle", int'(busy_o), 0);

      // vector table: R5 results and timing, R6 over-range
      for (int v = 0; v < NV; v++) begin
         thr = THR[v];
         pulse_start(1);
         wait_done(n);
         chk((E_OVR[v] != 0) ? "R6" : "R5", $sformatf("code thr=%0d", THR[v]), int'(code_o), E_CODE[v]);
         chk((E_OVR[v] != 0) ? "R6" : "R4", $sformatf("ovr thr=%0d", THR[v]), int'(ovr_o), E_OVR[v]);
         chk("R5", $sformatf("edges thr=%0d", THR[v]), n, E_CYC[v]);
      end

      // R9 and R2: start after over-range clears flag; held start ignores comparator
      thr = -1;
      @(negedge clk);
      start_i = 1'b1;
      repeat (5) @(negedge clk);
      chk("R9", "ovr cleared by start", int'(ovr_o), 0);
      chk("R2", "code held at zero", int'(code_o), 0);
      chk("R2", "busy while start held", int'(busy_o), 1);
      start_i = 1'b0;
      wait_done(n);
      chk("R4", "code on immediate cross", int'(code_o), 0);

      // R7: comparator moves after done
      thr = 40;
      pulse_start(1);
      wait_done(n);
      chk("R5", "code thr=40", int'(code_o), 41);
      thr = 1000;
      repeat (20) @(negedge clk);
      chk("R7", "code held after done", int'(code_o), 41);
      chk("R7", "busy stays low", int'(busy_o), 0);
      chk("R7", "ovr stays low", int'(ovr_o), 0);

      // R3 and R8: abort mid ramp
      thr = 200;
      pulse_start(1);
      repeat (50) @(posedge clk);
      #1;
      chk("R3", "code after 50 edges", int'(code_o), 50);
      chk("R3", "busy mid ramp", int'(busy_o), 1);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      chk("R8", "code after abort", int'(code_o), 0);
      chk("R8", "busy after abort", int'(busy_o), 1);
      start_i = 1'b0;
      thr = 10;
      wait_done(n);
      chk("R8", "code after restart", int'(code_o), 11);
      chk("R8", "edges after restart", n, 12);

      if (TOP != 255) chk("R6", "top code", TOP, 255);
      finish_run();
   end
endmodule